// File: doc/BRIEF.md
# Write-Masked PHY Control Register Block

This block is a small set of 32-bit control registers on a simple single-cycle bus. Every write carries its own bit mask: the upper half of the write word selects which bits of the lower half are allowed to change, so software can alter one field without first reading the register back. Bits whose mask bit is clear keep their value.

One register drives a narrow PHY configuration port made of a 6-bit address, a 4-bit data nibble and a write strobe. Software loads the address and data first, then raises the strobe, then lowers it. A 64-entry by 4-bit store inside the block stands in for the PHY's configuration space, so the block can be tested on its own. A second register holds one idle (lane-off) control bit for each of four lanes. A read-only status register returns two PLL condition inputs and the store entry at the address currently held in the configuration register.

Top module: `phy_cfg_regs`

## Requirements
- R1: On a write, bit x (0 to 15) of the addressed register takes bit x of the write data only when bit x+16 of the write data is 1. Every other bit keeps its value.
- R2: The configuration register is at word address 0. Its bits 6:1 drive `cfg_addr_o`, bits 10:7 drive `cfg_data_o` and bit 0 drives `cfg_stb_o`.
- R3: When `cfg_stb_o` rises, the value on `cfg_data_o` is written into the store entry selected by `cfg_addr_o`. The write takes effect on the clock edge after the edge that raised the strobe. While the strobe stays high, later changes to the address or data are not committed.
- R4: The lane-off register is at word address 1. Its bits 3, 4, 5 and 6 drive `lane_idle_o[0]` to `lane_idle_o[3]`, and a 1 places that lane in idle.
- R5: The status register is at word address 2 and is read-only. Bit 9 returns `pll_locked_i`, bit 10 returns `pll_oe_pend_i`, and bits 3:0 return the store entry addressed by `cfg_addr_o`. Writes to it change nothing.
- R6: Read data bits 31:16 are always 0. Bits that a register does not implement read as 0: bits 15:11 of the configuration register, and bits 15:7 and 2:0 of the lane-off register.
- R7: Writes to any word address other than 0, 1 and 2 change nothing, and reads from those addresses return 0.
- R8: After reset, both writable registers and every store entry are 0.
- R9: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write enable for one cycle |
| bus_rd | input | 1 | Read enable |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data; bits 31:16 are the per-bit mask |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| pll_locked_i | input | 1 | PLL locked condition |
| pll_oe_pend_i | input | 1 | PLL output-enable pending condition |
| cfg_addr_o | output | 6 | Configuration port address |
| cfg_data_o | output | 4 | Configuration port data |
| cfg_stb_o | output | 1 | Configuration port write strobe |
| lane_idle_o | output | 4 | Per-lane idle control |

## Verification
The assertions check four things on every cycle: a strobe rise commits the data that was on the port, a strobe held high leaves the store alone, a write whose lane mask bits are clear leaves the lane outputs unchanged, and a write to an undecoded address leaves all control outputs unchanged. Other behaviour can only be shown by the bench scenarios, since it depends on the values software writes. This includes the three-step configuration sequence and the store contents read back through status, the exact bit placement of every field, the zeros in unimplemented and upper bits, and mask merging under random data. The bench compares all of these against its own reference model.

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs #(
  parameter int AW       = 4,
  parameter int CA_W     = 6,
  parameter int CD_W     = 4,
  parameter int LANES    = 4,
  parameter int LANE_LSB = 3,
  parameter int LOCK_BIT = 9,
  parameter int OEP_BIT  = 10,
  parameter int CFG_OFS  = 0,
  parameter int LANE_OFS = 1,
  parameter int STAT_OFS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            pll_locked_i,
  input  logic            pll_oe_pend_i,
  output logic [CA_W-1:0] cfg_addr_o,
  output logic [CD_W-1:0] cfg_data_o,
  output logic            cfg_stb_o,
  output logic [LANES-1:0] lane_idle_o
);
  localparam int DEPTH   = 1 << CA_W;
  localparam int CFG_TOP = CA_W + CD_W;
  localparam logic [15:0] CFG_IMPL  = 16'((1 << (CFG_TOP + 1)) - 1);
  localparam logic [15:0] LANE_IMPL = 16'(((1 << LANES) - 1) << LANE_LSB);

  logic [15:0] cfg_q, lane_q, wmask, wval;
  logic        stb_d;
  logic [DEPTH-1:0][CD_W-1:0] mem_q;

  wire sel_cfg  = bus_addr == AW'(CFG_OFS);
  wire sel_lane = bus_addr == AW'(LANE_OFS);
  wire sel_stat = bus_addr == AW'(STAT_OFS);
  wire commit   = cfg_stb_o & ~stb_d;

  assign wmask = bus_wdata[31:16];
  assign wval  = bus_wdata[15:0];

  assign cfg_stb_o   = cfg_q[0];
  assign cfg_addr_o  = cfg_q[CA_W:1];
  assign cfg_data_o  = cfg_q[CFG_TOP:CA_W+1];
  assign lane_idle_o = lane_q[LANE_LSB +: LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lane_q <= '0;
      stb_d  <= 1'b0;
    end else begin
      stb_d <= cfg_q[0];
      if (bus_wr && sel_cfg)
        cfg_q <= (cfg_q & ~(wmask & CFG_IMPL)) | (wval & wmask & CFG_IMPL);
      if (bus_wr && sel_lane)
        lane_q <= (lane_q & ~(wmask & LANE_IMPL)) | (wval & wmask & LANE_IMPL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (commit) mem_q[cfg_addr_o] <= cfg_data_o;
  end

  logic [15:0] stat_w;
  always_comb begin
    stat_w = '0;
    stat_w[CD_W-1:0] = mem_q[cfg_addr_o];
    stat_w[LOCK_BIT] = pll_locked_i;
    stat_w[OEP_BIT]  = pll_oe_pend_i;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_cfg)       bus_rdata = {16'h0, cfg_q};
      else if (sel_lane) bus_rdata = {16'h0, lane_q};
      else if (sel_stat) bus_rdata = {16'h0, stat_w};
    end
  end

  a_r3_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_stb_o) |=> mem_q[$past(cfg_addr_o)] == $past(cfg_data_o));

  a_r3_no_commit_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stb_o && stb_d) |=> $stable(mem_q));

  a_r1_lane_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_lane && wmask[LANE_LSB +: LANES] == '0) |=> $stable(lane_idle_o));

  a_r7_undecoded_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sel_cfg && !sel_lane) |=>
      ($stable(lane_idle_o) && $stable(cfg_addr_o) && $stable(cfg_data_o) && $stable(cfg_stb_o)));
endmodule

// File: tb/tb_phy_cfg_regs.sv
module tb_phy_cfg_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, lock = 0, oep = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0] cfg_addr_o;
  logic [3:0] cfg_data_o, lane_idle_o;
  logic cfg_stb_o;

  phy_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_locked_i(lock), .pll_oe_pend_i(oep),
    .cfg_addr_o(cfg_addr_o), .cfg_data_o(cfg_data_o), .cfg_stb_o(cfg_stb_o),
    .lane_idle_o(lane_idle_o));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [10:0] m_cfg = '0;
  logic [3:0]  m_lane = '0;
  logic        m_stb_d = 0;
  logic [3:0]  m_mem [64];

  function automatic logic [31:0] exp_rd(input logic rd, input logic [3:0] a);
    if (!rd) return 32'h0;
    case (a)
      4'd0: return {21'h0, m_cfg};
      4'd1: return {25'h0, m_lane, 3'b000};
      4'd2: return {21'h0, oep, lock, 5'h0, m_mem[m_cfg[6:1]]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [31:0] d, input string tag);
    logic [15:0] t;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    check(rd ? tag : "R9 idle read bus", bus_rdata, exp_rd(rd, a));
    check("R2 cfg port", {21'h0, cfg_data_o, cfg_addr_o, cfg_stb_o}, {21'h0, m_cfg});
    check("R4 lane outputs", {28'h0, lane_idle_o}, {28'h0, m_lane});
    @(posedge clk);
    if (m_cfg[0] && !m_stb_d) m_mem[m_cfg[6:1]] = m_cfg[10:7];
    m_stb_d = m_cfg[0];
    if (wr && a == 4'd0) begin
      t = merge({5'h0, m_cfg}, d); m_cfg = t[10:0];
    end
    if (wr && a == 4'd1) begin
      t = merge({9'h0, m_lane, 3'b000}, d); m_lane = t[6:3];
    end
  endtask

  function automatic string tag_for(input logic [3:0] a);
    case (a)
      4'd0: return "R1 R2 cfg read";
      4'd1: return "R1 R4 lane read";
      4'd2: return "R5 status read";
      default: return "R7 undecoded read";
    endcase
  endfunction

  initial begin
    foreach (m_mem[i]) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R8 reset state
    cycle(0, 1, 4'd0, 0, "R8 cfg after reset");
    cycle(0, 1, 4'd1, 0, "R8 lane after reset");
    cycle(0, 1, 4'd2, 0, "R8 store after reset");
    // R3 three-step configuration sequence: addr 5, data 0xA
    cycle(1, 0, 4'd0, {16'h07FE, 5'h0, 4'hA, 6'd5, 1'b0}, "R3");
    cycle(1, 0, 4'd0, 32'h0001_0001, "R3");
    cycle(1, 0, 4'd0, 32'h0001_0000, "R3");
    cycle(0, 1, 4'd2, 0, "R3 commit readback");
    check("R3 committed nibble", {28'h0, bus_rdata[3:0]}, 32'hA);
    // R3 strobe held high: data change must not commit
    cycle(1, 0, 4'd0, 32'h0001_0001, "R3");
    cycle(1, 0, 4'd0, {16'h0780, 5'h0, 4'h3, 7'h0}, "R3");
    cycle(0, 1, 4'd2, 0, "R3 held strobe");
    cycle(0, 1, 4'd2, 0, "R3 held strobe");
    check("R3 held strobe nibble", {28'h0, bus_rdata[3:0]}, 32'hA);
    cycle(1, 0, 4'd0, 32'h0001_0000, "R3");
    // R1 write with empty mask
    cycle(1, 0, 4'd1, 32'h0000_FFFF, "R1");
    cycle(0, 1, 4'd1, 0, "R1 empty mask lane");
    // R4 single lane idle
    cycle(1, 0, 4'd1, 32'h0020_0020, "R4");
    cycle(0, 1, 4'd1, 0, "R4 lane C idle");
    check("R4 lane C output", {28'h0, lane_idle_o}, 32'h4);
    // R5 status write ignored, pll bits
    lock = 1; oep = 1;
    cycle(1, 1, 4'd2, 32'hFFFF_FFFF, "R5 status pll bits");
    // R7 undecoded write/read
    cycle(1, 0, 4'd5, 32'hFFFF_FFFF, "R7");
    cycle(0, 1, 4'd5, 0, "R7 undecoded read zero");
    // R6 upper and unimplemented bits
    cycle(1, 0, 4'd0, 32'hFFFF_FFFE, "R6");
    cycle(0, 1, 4'd0, 0, "R6 cfg read");
    check("R6 cfg width", bus_rdata, 32'h0000_07FE);
    cycle(1, 0, 4'd1, 32'hFFFF_FFFF, "R6");
    cycle(0, 1, 4'd1, 0, "R6 lane read");
    check("R6 lane width", bus_rdata, 32'h0000_0078);
    // random mix
    void'($urandom(32'h1234));
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      lock = 1'($urandom); oep = 1'($urandom);
      a = 4'($urandom_range(0, 5));
      cycle(1'($urandom), 1'($urandom), a, $urandom, tag_for(a));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule